// File: doc/BRIEF.md
# Control Register Window Decoder

This block routes one upstream control-register bus to several downstream control-register buses. Each downstream bus sits in its own address window. When the block is built, the windows are laid out one after another, from the lowest address upwards. Each window is as large as its downstream address space (2^AW locations) and starts on a multiple of its own size. A window may also ask for a coarser power-of-two boundary, which leaves a hole in the map below it.

During operation the decoder compares the upstream address against every window in the same cycle. Read and write strobes go only to the matching downstream bus. That bus also receives the address offset within its window, and every downstream bus receives the write data. Downstream buses return read data one cycle after the read strobe. The decoder therefore registers which window was read and returns that bus's data upstream in the next cycle. A single-cycle read pipeline is thus kept intact across windows.

With the default parameters there are four downstream buses with address widths 10, 10, 10 and 8. The third bus requests a 4 KiB boundary. This gives the windows 0x0000–0x03FF, 0x0400–0x07FF, 0x1000–0x13FF and 0x1400–0x14FF.

Top module: `csr_window_decoder`

## Requirements
- R1: Windows are placed in index order. Each window starts at the first free address that is a multiple of its size 2^AW, and spans exactly 2^AW addresses. By default the bases are 0x0000, 0x0400, 0x1000 and 0x1400, with sizes 0x400, 0x400, 0x400 and 0x100.
- R2: In the cycle the upstream address lies inside window i, an upstream read or write strobe appears only on bit i of the matching downstream strobe vector. Every other bit is low, and no downstream strobe is high without the upstream strobe.
- R3: An address outside every window, such as 0x0800 or anything from 0x1500 upwards, produces no downstream strobe.
- R4: Slot i of the downstream address carries the upstream address bits [AW_i-1:0]. Slot bits above AW_i are zero. Upstream 0x0402 gives offset 2 on bus 1.
- R5: Every downstream write-data slot equals the upstream write data in the same cycle.
- R6: After a read strobe to window i in cycle N, the upstream read data in cycle N+1 equals downstream read-data slot i.
- R7: Reads to different windows in consecutive cycles return each bus's data in consecutive cycles, in the order issued.
- R8: The upstream read data is zero in any cycle that follows a cycle without a read strobe to a mapped address.
- R9: While reset is asserted and after its release, up to the first read, the upstream read data is zero.
- R10: A window with an alignment request of 2^A starts on a multiple of max(2^A, 2^AW). The hole left below it, 0x0800–0x0FFF by default, is unmapped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| up_addr | input | UP_AW | Upstream address |
| up_rd_stb | input | 1 | Upstream read strobe |
| up_wr_stb | input | 1 | Upstream write strobe |
| up_wr_data | input | DW | Upstream write data |
| up_rd_data | output | DW | Upstream read data, one cycle after the read strobe |
| dn_addr | output | NUM_SUBS*SLOT_AW | Per-bus window offset, slot i at bits [i*SLOT_AW +: SLOT_AW] |
| dn_rd_stb | output | NUM_SUBS | Per-bus read strobe |
| dn_wr_stb | output | NUM_SUBS | Per-bus write strobe |
| dn_wr_data | output | NUM_SUBS*DW | Per-bus write data, slot i at bits [i*DW +: DW] |
| dn_rd_data | input | NUM_SUBS*DW | Per-bus read data, slot i at bits [i*DW +: DW] |

## Verification
Strobes, offsets and write data are combinational, so they are due in the same cycle as the upstream address. The bench checks them after the inputs change on the falling edge and before the next rising edge. Read data passes through one register and is due one cycle after the read strobe. The bench samples it a moment after the following rising edge, before new inputs are applied. Back-to-back reads are checked on two successive edges, so a lag or lead of one cycle shows up as a wrong value.

// File: rtl/csr_dec_pkg.sv
package csr_dec_pkg;

  // Width of an index able to name n items, never below one bit.
  function automatic int unsigned idx_width(int unsigned n);
    return (n > 1) ? $clog2(n) : 1;
  endfunction

  // Round v upwards to a multiple of 2^sh.
  function automatic longint unsigned round_up_pow2(longint unsigned v, int unsigned sh);
    longint unsigned step;
    step = 64'd1 << sh;
    return (v + step - 64'd1) & ~(step - 64'd1);
  endfunction

endpackage

// File: rtl/csr_dec_window_map.sv
module csr_dec_window_map
  import csr_dec_pkg::*;
#(
  parameter int unsigned UP_AW                 = 16,
  parameter int unsigned NUM_SUBS              = 4,
  parameter int unsigned SUB_AW    [NUM_SUBS]  = '{10, 10, 10, 8},
  parameter int unsigned SUB_ALIGN [NUM_SUBS]  = '{0, 0, 12, 0},
  parameter int unsigned IDX_W                 = idx_width(NUM_SUBS)
) (
  input  logic [UP_AW-1:0]    up_addr,
  output logic [NUM_SUBS-1:0] hit,
  output logic                any_hit,
  output logic [IDX_W-1:0]    hit_idx
);

  localparam longint unsigned SPACE = 64'd1 << UP_AW;

  // Base of window k under sequential, size- and alignment-rounded placement.
  function automatic longint unsigned win_base(int unsigned k);
    longint unsigned cur;
    longint unsigned res;
    int unsigned     sh;
    cur = 0;
    res = 0;
    for (int unsigned j = 0; j < NUM_SUBS; j++) begin
      sh  = (SUB_AW[j] > SUB_ALIGN[j]) ? SUB_AW[j] : SUB_ALIGN[j];
      cur = round_up_pow2(cur, sh);
      if (j == k) res = cur;
      cur = cur + (64'd1 << SUB_AW[j]);
    end
    return res;
  endfunction

  for (genvar i = 0; i < NUM_SUBS; i++) begin : g_win
    localparam int unsigned     AWI    = SUB_AW[i];
    localparam longint unsigned BASE_L = win_base(i);
    localparam logic [63:0]     BASE_V = BASE_L;

    if (AWI < 1 || AWI >= UP_AW) begin : g_bad_width
      $error("window %0d address width %0d out of range", i, AWI);
    end
    if (BASE_L + (64'd1 << AWI) > SPACE) begin : g_bad_fit
      $error("window %0d does not fit the upstream address space", i);
    end

    assign hit[i] = (up_addr[UP_AW-1:AWI] == BASE_V[UP_AW-1:AWI]);
  end

  always_comb begin
    hit_idx = '0;
    for (int unsigned i = 0; i < NUM_SUBS; i++) begin
      if (hit[i]) hit_idx = hit_idx | IDX_W'(i);
    end
  end

  assign any_hit = |hit;

endmodule

// File: rtl/csr_dec_route.sv
module csr_dec_route #(
  parameter int unsigned NUM_SUBS             = 4,
  parameter int unsigned DW                   = 8,
  parameter int unsigned SLOT_AW              = 10,
  parameter int unsigned SUB_AW  [NUM_SUBS]   = '{10, 10, 10, 8}
) (
  input  logic [SLOT_AW-1:0]          up_addr_lo,
  input  logic                        up_rd_stb,
  input  logic                        up_wr_stb,
  input  logic [DW-1:0]               up_wr_data,
  input  logic [NUM_SUBS-1:0]         hit,
  output logic [NUM_SUBS*SLOT_AW-1:0] dn_addr,
  output logic [NUM_SUBS-1:0]         dn_rd_stb,
  output logic [NUM_SUBS-1:0]         dn_wr_stb,
  output logic [NUM_SUBS*DW-1:0]      dn_wr_data
);

  for (genvar i = 0; i < NUM_SUBS; i++) begin : g_slot
    localparam int unsigned AWI = SUB_AW[i];

    if (AWI > SLOT_AW) begin : g_bad_slot
      $error("window %0d address width exceeds slot width", i);
    end

    if (AWI == SLOT_AW) begin : g_full
      assign dn_addr[i*SLOT_AW +: SLOT_AW] = up_addr_lo;
    end else begin : g_part
      assign dn_addr[i*SLOT_AW +: SLOT_AW] = {{(SLOT_AW-AWI){1'b0}}, up_addr_lo[AWI-1:0]};
    end

    assign dn_rd_stb[i]             = up_rd_stb & hit[i];
    assign dn_wr_stb[i]             = up_wr_stb & hit[i];
    assign dn_wr_data[i*DW +: DW]   = up_wr_data;
  end

endmodule

// File: rtl/csr_dec_rd_return.sv
module csr_dec_rd_return #(
  parameter int unsigned NUM_SUBS = 4,
  parameter int unsigned DW       = 8,
  parameter int unsigned IDX_W    = 2
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   up_rd_stb,
  input  logic                   any_hit,
  input  logic [IDX_W-1:0]       hit_idx,
  input  logic [NUM_SUBS*DW-1:0] dn_rd_data,
  output logic [DW-1:0]          up_rd_data
);

  logic             rd_vld_q, rd_vld_d;
  logic [IDX_W-1:0] rd_idx_q, rd_idx_d;
  logic             rd_idx_en;

  always_comb begin
    rd_idx_en = up_rd_stb & any_hit;
    rd_vld_d  = rd_idx_en;
    rd_idx_d  = rd_idx_q;
    if (rd_idx_en) rd_idx_d = hit_idx;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rd_vld_q <= 1'b0;
      rd_idx_q <= '0;
    end else begin
      rd_vld_q <= rd_vld_d;
      rd_idx_q <= rd_idx_d;
    end
  end

  always_comb begin
    up_rd_data = '0;
    for (int unsigned i = 0; i < NUM_SUBS; i++) begin
      if (rd_vld_q && (rd_idx_q == IDX_W'(i))) up_rd_data = dn_rd_data[i*DW +: DW];
    end
  end

endmodule

// File: rtl/csr_window_decoder.sv
module csr_window_decoder
  import csr_dec_pkg::*;
#(
  parameter int unsigned UP_AW                 = 16,
  parameter int unsigned DW                    = 8,
  parameter int unsigned NUM_SUBS              = 4,
  parameter int unsigned SLOT_AW               = 10,
  parameter int unsigned SUB_AW    [NUM_SUBS]  = '{10, 10, 10, 8},
  parameter int unsigned SUB_ALIGN [NUM_SUBS]  = '{0, 0, 12, 0}
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic [UP_AW-1:0]            up_addr,
  input  logic                        up_rd_stb,
  input  logic                        up_wr_stb,
  input  logic [DW-1:0]               up_wr_data,
  output logic [DW-1:0]               up_rd_data,
  output logic [NUM_SUBS*SLOT_AW-1:0] dn_addr,
  output logic [NUM_SUBS-1:0]         dn_rd_stb,
  output logic [NUM_SUBS-1:0]         dn_wr_stb,
  output logic [NUM_SUBS*DW-1:0]      dn_wr_data,
  input  logic [NUM_SUBS*DW-1:0]      dn_rd_data
);

  localparam int unsigned IDX_W = idx_width(NUM_SUBS);

  logic [NUM_SUBS-1:0] hit;
  logic                any_hit;
  logic [IDX_W-1:0]    hit_idx;

  csr_dec_window_map #(
    .UP_AW     (UP_AW),
    .NUM_SUBS  (NUM_SUBS),
    .SUB_AW    (SUB_AW),
    .SUB_ALIGN (SUB_ALIGN),
    .IDX_W     (IDX_W)
  ) i_map (
    .up_addr (up_addr),
    .hit     (hit),
    .any_hit (any_hit),
    .hit_idx (hit_idx)
  );

  csr_dec_route #(
    .NUM_SUBS (NUM_SUBS),
    .DW       (DW),
    .SLOT_AW  (SLOT_AW),
    .SUB_AW   (SUB_AW)
  ) i_route (
    .up_addr_lo (up_addr[SLOT_AW-1:0]),
    .up_rd_stb  (up_rd_stb),
    .up_wr_stb  (up_wr_stb),
    .up_wr_data (up_wr_data),
    .hit        (hit),
    .dn_addr    (dn_addr),
    .dn_rd_stb  (dn_rd_stb),
    .dn_wr_stb  (dn_wr_stb),
    .dn_wr_data (dn_wr_data)
  );

  csr_dec_rd_return #(
    .NUM_SUBS (NUM_SUBS),
    .DW       (DW),
    .IDX_W    (IDX_W)
  ) i_ret (
    .clk        (clk),
    .rst_n      (rst_n),
    .up_rd_stb  (up_rd_stb),
    .any_hit    (any_hit),
    .hit_idx    (hit_idx),
    .dn_rd_data (dn_rd_data),
    .up_rd_data (up_rd_data)
  );

endmodule

// File: rtl/csr_window_decoder_chk.sv
module csr_window_decoder_chk #(
  parameter int unsigned DW       = 8,
  parameter int unsigned NUM_SUBS = 4
) (
  input logic                   clk,
  input logic                   rst_n,
  input logic                   up_rd_stb,
  input logic                   up_wr_stb,
  input logic [DW-1:0]          up_rd_data,
  input logic [NUM_SUBS-1:0]    dn_rd_stb,
  input logic [NUM_SUBS-1:0]    dn_wr_stb,
  input logic [NUM_SUBS*DW-1:0] dn_rd_data
);

  AST_RD_STB_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(dn_rd_stb)); // R2
  AST_WR_STB_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(dn_wr_stb)); // R2
  AST_RD_STB_NEEDS_UP: assert property (@(posedge clk) disable iff (!rst_n)
    (dn_rd_stb != '0) |-> up_rd_stb); // R2
  AST_WR_STB_NEEDS_UP: assert property (@(posedge clk) disable iff (!rst_n)
    (dn_wr_stb != '0) |-> up_wr_stb); // R2
  AST_RD_ZERO_NO_READ: assert property (@(posedge clk) disable iff (!rst_n)
    (dn_rd_stb == '0) |=> (up_rd_data == '0)); // R8

  for (genvar i = 0; i < NUM_SUBS; i++) begin : g_ret
    AST_RD_RETURN: assert property (@(posedge clk) disable iff (!rst_n)
      dn_rd_stb[i] |=> (up_rd_data == dn_rd_data[i*DW +: DW])); // R6
  end

endmodule

bind csr_window_decoder csr_window_decoder_chk #(
  .DW       (DW),
  .NUM_SUBS (NUM_SUBS)
) i_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .up_rd_stb  (up_rd_stb),
  .up_wr_stb  (up_wr_stb),
  .up_rd_data (up_rd_data),
  .dn_rd_stb  (dn_rd_stb),
  .dn_wr_stb  (dn_wr_stb),
  .dn_rd_data (dn_rd_data)
);

// File: tb/test_csr_window_decoder.sv
module test_csr_window_decoder;

  localparam int NS = 4;
  localparam int DW = 8;
  localparam int SA = 10;

  localparam logic [15:0] BASE [NS] = '{16'h0000, 16'h0400, 16'h1000, 16'h1400};
  localparam logic [15:0] SIZE [NS] = '{16'h0400, 16'h0400, 16'h0400, 16'h0100};
  localparam int          AWS  [NS] = '{10, 10, 10, 8};

  logic              clk;
  logic              rst_n;
  logic [15:0]       up_addr;
  logic              up_rd_stb;
  logic              up_wr_stb;
  logic [DW-1:0]     up_wr_data;
  logic [DW-1:0]     up_rd_data;
  logic [NS*SA-1:0]  dn_addr;
  logic [NS-1:0]     dn_rd_stb;
  logic [NS-1:0]     dn_wr_stb;
  logic [NS*DW-1:0]  dn_wr_data;
  logic [NS*DW-1:0]  dn_rd_data;

  int n_chk;
  int n_bad;
  bit done;

  csr_window_decoder i_csr_window_decoder (
    .clk        (clk),
    .rst_n      (rst_n),
    .up_addr    (up_addr),
    .up_rd_stb  (up_rd_stb),
    .up_wr_stb  (up_wr_stb),
    .up_wr_data (up_wr_data),
    .up_rd_data (up_rd_data),
    .dn_addr    (dn_addr),
    .dn_rd_stb  (dn_rd_stb),
    .dn_wr_stb  (dn_wr_stb),
    .dn_wr_data (dn_wr_data),
    .dn_rd_data (dn_rd_data)
  );

  initial clk = 1'b0;
  always #4 clk = ~clk;

  function automatic logic [DW-1:0] sub_val(int i);
    return DW'(8'h10 * (i + 1) + i);
  endfunction

  task automatic chk(string req, logic [63:0] act, logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  // drive on the falling edge, let combinational outputs settle
  task automatic drive(logic [15:0] a, logic rd, logic wr, logic [DW-1:0] wd);
    @(negedge clk);
    up_addr = a; up_rd_stb = rd; up_wr_stb = wr; up_wr_data = wd;
    #1;
  endtask

  task automatic idle();
    drive(16'h0000, 1'b0, 1'b0, 8'h00);
  endtask

  task automatic t_reset();
    rst_n = 1'b0;
    up_addr = '0; up_rd_stb = 1'b0; up_wr_stb = 1'b0; up_wr_data = '0;
    for (int i = 0; i < NS; i++) dn_rd_data[i*DW +: DW] = sub_val(i);
    repeat (3) @(posedge clk);
    #1 chk("R9 rd_data in reset", up_rd_data, 0);
    @(negedge clk); rst_n = 1'b1;
    @(posedge clk); #1;
    chk("R9 rd_data after reset", up_rd_data, 0);
    chk("R2 no strobes idle", {dn_rd_stb, dn_wr_stb}, 0);
  endtask

  task automatic t_placement();
    for (int i = 0; i < NS; i++) begin
      drive(BASE[i], 1'b0, 1'b1, 8'h00);
      chk("R1 base hits own window", dn_wr_stb, 64'(1 << i));
      chk("R2 no read strobe on write", dn_rd_stb, 0);
      drive(BASE[i] + SIZE[i] - 16'd1, 1'b0, 1'b1, 8'h00);
      chk("R1 last address in window", dn_wr_stb, 64'(1 << i));
      chk("R4 offset at window end", dn_addr[i*SA +: SA], 64'((1 << AWS[i]) - 1));
    end
    drive(16'h03FF, 1'b1, 1'b0, 8'h00);
    chk("R2 read strobe below window 1", dn_rd_stb, 1);
    idle();
  endtask

  task automatic t_unmapped();
    logic [15:0] holes [5] = '{16'h0800, 16'h0FFF, 16'h0C34, 16'h1500, 16'hFFFF};
    for (int k = 0; k < 5; k++) begin
      drive(holes[k], 1'b1, 1'b1, 8'hA5);
      chk(k < 3 ? "R10 alignment hole unmapped" : "R3 above windows unmapped",
          {dn_rd_stb, dn_wr_stb}, 0);
      @(posedge clk); #1;
      chk("R8 unmapped read returns zero", up_rd_data, 0);
    end
    idle();
  endtask

  task automatic t_offset();
    drive(16'h0402, 1'b0, 1'b1, 8'h00);
    chk("R4 offset 2 on bus 1", dn_addr[1*SA +: SA], 2);
    drive(16'h14AB, 1'b0, 1'b1, 8'h00);
    chk("R4 narrow bus offset zero-extended", dn_addr[3*SA +: SA], 16'h0AB);
    chk("R2 narrow bus strobe", dn_wr_stb, 4'b1000);
    drive(16'h1357, 1'b0, 1'b1, 8'h00);
    chk("R4 aligned window offset", dn_addr[2*SA +: SA], 16'h357);
    idle();
  endtask

  task automatic t_wdata();
    drive(16'h1001, 1'b0, 1'b1, 8'h5A);
    for (int i = 0; i < NS; i++)
      chk("R5 write data on every slot", dn_wr_data[i*DW +: DW], 8'h5A);
    drive(16'h0001, 1'b0, 1'b1, 8'hC3);
    chk("R5 write data follows upstream", dn_wr_data[3*DW +: DW], 8'hC3);
    idle();
  endtask

  task automatic t_read();
    for (int i = 0; i < NS; i++) begin
      drive(BASE[i] + 16'd3, 1'b1, 1'b0, 8'h00);
      chk("R2 read strobe to own window", dn_rd_stb, 64'(1 << i));
      @(posedge clk); #1;
      chk("R6 read data next cycle", up_rd_data, sub_val(i));
      idle();
      @(posedge clk); #1;
      chk("R8 zero after idle cycle", up_rd_data, 0);
    end
  endtask

  task automatic t_b2b();
    drive(16'h0000, 1'b1, 1'b0, 8'h00);
    @(posedge clk); #1;
    chk("R7 first of back-to-back", up_rd_data, sub_val(0));
    drive(16'h0402, 1'b1, 1'b0, 8'h00);
    @(posedge clk); #1;
    chk("R7 second of back-to-back", up_rd_data, sub_val(1));
    drive(16'h1480, 1'b1, 1'b0, 8'h00);
    @(posedge clk); #1;
    chk("R7 third of back-to-back", up_rd_data, sub_val(3));
    drive(16'h2000, 1'b1, 1'b0, 8'h00);
    @(posedge clk); #1;
    chk("R8 unmapped read ends burst", up_rd_data, 0);
    idle();
  endtask

  initial begin
    n_chk = 0; n_bad = 0; done = 1'b0;
    t_reset();
    t_placement();
    t_unmapped();
    t_offset();
    t_wdata();
    t_read();
    t_b2b();
    repeat (2) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end

endmodule